// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a processor and its memory system. It turns a 16-bit logical word address into a 20-bit physical word address, one 4K-word page at a time. The page register that is used depends on three things: whether the access is an instruction fetch, the 4-bit address-state field, and the top four logical address bits. The address state and the 4-bit access key are not supplied with each access. They come from a copy of the processor status word that the block holds internally.

Every page register stores a physical page number, a 4-bit access lock, a write-protect flag and an execute-protect flag. On each access the block compares the held key against the lock and applies the protection flags. It then returns, one clock later, the translated address together with either a hit or a fault pulse.

The processor programs the page registers and the held status word through trapped I/O commands. These arrive on a small command port, and each read command is answered on the following cycle.

Top module: `pxu_translate`

## Requirements
- R1: After reset every page register holds an identity mapping: page number equals the entry's logical page bits (index bits [3:0]), lock 0, neither flag set. The held status word is 0 (address state 0, key 0), and `out_valid` and `io_rsp_valid` are low.
- R2: An access presented with `acc_valid` high yields `out_valid` high on the next cycle, with `out_paddr` = {page number[7:0], `acc_laddr`[11:0]}.
- R3: The page register index is {select, address state[3:0], `acc_laddr`[15:12]}, with select = 1 only for an instruction fetch that is not a write. The same 9-bit index is used as `io_cmd_addr` on the command port.
- R4: Access is granted when the held key is 0, when the key equals the page lock, or when the lock is 4'hF.
- R5: When access is not granted, `out_fault` pulses high for that access and `out_hit` stays low.
- R6: A write (`acc_write`=1) to a page with the write-protect flag set faults with no hit. A read of that page is unaffected by the flag.
- R7: An instruction fetch to a page with the execute-protect flag set faults with no hit. An operand read, which uses a select-0 entry, is unaffected.
- R8: A page write command (`io_cmd_sel`=0, `io_cmd_wr`=1) stores `io_cmd_wdata` as {execute-protect[13], write-protect[12], lock[11:8], page number[7:0]} at `io_cmd_addr`. It governs accesses presented from the next cycle on.
- R9: A read command (`io_cmd_wr`=0) raises `io_rsp_valid` on the next cycle. `io_rsp_data` then carries the addressed page register in the R8 layout, or the status word in the R10 layout with the upper bits zero.
- R10: A status write command (`io_cmd_sel`=1, `io_cmd_wr`=1) loads the key from `io_cmd_wdata`[3:0] and the address state from `io_cmd_wdata`[7:4]. The address state then picks the mapping set used by later accesses.
- R11: In a cycle after which no access was presented, `out_valid`, `out_hit` and `out_fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_write | input | 1 | Access is an operand write |
| acc_laddr | input | 16 | Logical word address |
| io_cmd_valid | input | 1 | Trapped I/O command this cycle |
| io_cmd_wr | input | 1 | 1 = write command, 0 = read command |
| io_cmd_sel | input | 1 | 0 = page register, 1 = held status word |
| io_cmd_addr | input | 9 | Page register index |
| io_cmd_wdata | input | 14 | Command write data |
| io_rsp_valid | output | 1 | Read response valid |
| io_rsp_data | output | 14 | Read response data |
| out_valid | output | 1 | Translated access result valid |
| out_paddr | output | 20 | Physical word address |
| out_hit | output | 1 | Access granted and mapped |
| out_fault | output | 1 | Protection fault pulse |

## Verification
The assertions rely on a few conditions at the inputs. After reset the inputs carry known values. `acc_fetch` and `acc_write` matter only while `acc_valid` is high. At most one command arrives per cycle. The bench drives every input on the falling edge from tasks that return to idle values, so each access and each command occupies exactly one rising edge. It never combines a fetch with a write except to check that writes use the operand entries.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    parameter int LA_W    = 16;
    parameter int OFS_W   = 12;
    parameter int PPN_W   = 8;
    parameter int KEY_W   = 4;
    parameter int AS_W    = 4;
    localparam int PG_W    = LA_W - OFS_W;
    localparam int IDX_W   = 1 + AS_W + PG_W;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int PA_W    = PPN_W + OFS_W;
    localparam int PTE_W   = 2 + KEY_W + PPN_W;
    localparam int IO_W    = PTE_W;

    typedef struct packed {
        logic             ep;
        logic             wp;
        logic [KEY_W-1:0] lock;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        logic [AS_W-1:0]  as_f;
        logic [KEY_W-1:0] key;
    } psw_t;
endpackage

// File: rtl/pxu_status_reg.sv
module pxu_status_reg
    import pxu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IO_W-1:0] wr_data,
    output psw_t            psw,
    output logic [IO_W-1:0] rd_data
);
    typedef struct packed {
        psw_t held;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.held.key  = wr_data[KEY_W-1:0];
            st_d.held.as_f = wr_data[KEY_W +: AS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign psw     = st_q.held;
    assign rd_data = IO_W'(st_q.held);

    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> psw.key == $past(wr_data[KEY_W-1:0]) && psw.as_f == $past(wr_data[KEY_W +: AS_W])); // R10
endmodule

// File: rtl/pxu_page_table.sv
module pxu_page_table
    import pxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IO_W-1:0]  wr_data,
    input  logic [IDX_W-1:0] acc_idx,
    output pte_t             acc_pte,
    input  logic [IDX_W-1:0] io_idx,
    output logic [IO_W-1:0]  io_rdata
);
    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        pte_t             pte;
    } wr_t;

    pte_t table_q [ENTRIES];
    wr_t  wr_d;

    always_comb begin
        wr_d.en  = wr_en;
        wr_d.idx = wr_idx;
        wr_d.pte = pte_t'(wr_data[PTE_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                table_q[i].ep   <= 1'b0;
                table_q[i].wp   <= 1'b0;
                table_q[i].lock <= '0;
                table_q[i].ppn  <= PPN_W'(i % (1 << PG_W));
            end
        end else if (wr_d.en) begin
            table_q[wr_d.idx] <= wr_d.pte;
        end
    end

    assign acc_pte  = table_q[acc_idx];
    assign io_rdata = IO_W'(table_q[io_idx]);

    AST_ENTRY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> table_q[$past(wr_idx)] == $past(pte_t'(wr_data[PTE_W-1:0]))); // R8
endmodule

// File: rtl/pxu_access_check.sv
module pxu_access_check
    import pxu_pkg::*;
(
    input  pte_t             pte,
    input  logic [KEY_W-1:0] key,
    input  logic             is_write,
    input  logic             is_fetch,
    output logic             grant
);
    typedef struct packed {
        logic key_ok;
        logic wr_block;
        logic ex_block;
    } chk_t;

    chk_t chk_d;

    always_comb begin
        chk_d.key_ok   = (key == '0) || (key == pte.lock) || (&pte.lock);
        chk_d.wr_block = is_write && pte.wp;
        chk_d.ex_block = is_fetch && !is_write && pte.ep;
    end

    assign grant = chk_d.key_ok && !chk_d.wr_block && !chk_d.ex_block;
endmodule

// File: rtl/pxu_translate.sv
module pxu_translate
    import pxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_fetch,
    input  logic             acc_write,
    input  logic [LA_W-1:0]  acc_laddr,
    input  logic             io_cmd_valid,
    input  logic             io_cmd_wr,
    input  logic             io_cmd_sel,
    input  logic [IDX_W-1:0] io_cmd_addr,
    input  logic [IO_W-1:0]  io_cmd_wdata,
    output logic             io_rsp_valid,
    output logic [IO_W-1:0]  io_rsp_data,
    output logic             out_valid,
    output logic [PA_W-1:0]  out_paddr,
    output logic             out_hit,
    output logic             out_fault
);
    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            hit;
        logic            fault;
    } res_t;

    typedef struct packed {
        logic            valid;
        logic [IO_W-1:0] data;
    } rsp_t;

    res_t res_d, res_q;
    rsp_t rsp_d, rsp_q;

    psw_t             psw;
    pte_t             pte_acc;
    logic [IO_W-1:0]  tbl_rdata;
    logic [IO_W-1:0]  psw_rdata;
    logic [IDX_W-1:0] acc_idx;
    logic             grant;
    logic             tbl_wr;
    logic             psw_wr;

    assign acc_idx = {acc_fetch & ~acc_write, psw.as_f, acc_laddr[LA_W-1:OFS_W]};
    assign tbl_wr  = io_cmd_valid && io_cmd_wr && !io_cmd_sel;
    assign psw_wr  = io_cmd_valid && io_cmd_wr && io_cmd_sel;

    pxu_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (psw_wr),
        .wr_data (io_cmd_wdata),
        .psw     (psw),
        .rd_data (psw_rdata)
    );

    pxu_page_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (io_cmd_addr),
        .wr_data  (io_cmd_wdata),
        .acc_idx  (acc_idx),
        .acc_pte  (pte_acc),
        .io_idx   (io_cmd_addr),
        .io_rdata (tbl_rdata)
    );

    pxu_access_check u_check (
        .pte      (pte_acc),
        .key      (psw.key),
        .is_write (acc_write),
        .is_fetch (acc_fetch),
        .grant    (grant)
    );

    always_comb begin
        res_d.valid = acc_valid;
        res_d.paddr = {pte_acc.ppn, acc_laddr[OFS_W-1:0]};
        res_d.hit   = acc_valid && grant;
        res_d.fault = acc_valid && !grant;
        rsp_d.valid = io_cmd_valid && !io_cmd_wr;
        rsp_d.data  = io_cmd_sel ? psw_rdata : tbl_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            rsp_q <= '0;
        end else begin
            res_q <= res_d;
            rsp_q <= rsp_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_paddr    = res_q.paddr;
    assign out_hit      = res_q.hit;
    assign out_fault    = res_q.fault;
    assign io_rsp_valid = rsp_q.valid;
    assign io_rsp_data  = rsp_q.data;

    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> out_valid); // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> out_paddr[OFS_W-1:0] == $past(acc_laddr[OFS_W-1:0])); // R2
    AST_FAULT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> !out_hit); // R5
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && pte_acc.wp |=> out_fault); // R6
    AST_EP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_fetch && !acc_write && pte_acc.ep |=> out_fault); // R7
    AST_KEY_ZERO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && psw.key == '0 && !pte_acc.wp && !pte_acc.ep |=> out_hit); // R4
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        io_cmd_valid && !io_cmd_wr |=> io_rsp_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_hit && !out_fault); // R11
endmodule

// File: tb/pxu_translate_tb.sv
module pxu_translate_tb;
    import pxu_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0, acc_fetch = 1'b0, acc_write = 1'b0;
    logic [LA_W-1:0]  acc_laddr = '0;
    logic             io_cmd_valid = 1'b0, io_cmd_wr = 1'b0, io_cmd_sel = 1'b0;
    logic [IDX_W-1:0] io_cmd_addr = '0;
    logic [IO_W-1:0]  io_cmd_wdata = '0;
    logic             io_rsp_valid, out_valid, out_hit, out_fault;
    logic [IO_W-1:0]  io_rsp_data;
    logic [PA_W-1:0]  out_paddr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pxu_translate u_dut (.*);

    typedef struct {
        logic [PA_W-1:0] paddr;
        logic            hit;
        logic            fault;
        string           tag;
    } exp_t;

    exp_t exp_q[$];

    logic [PTE_W-1:0] mdl_pte [ENTRIES];
    logic [AS_W-1:0]  mdl_as;
    logic [KEY_W-1:0] mdl_key;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(string tag, logic fetch, logic wr, logic [LA_W-1:0] la);
        exp_t e;
        logic [IDX_W-1:0] idx;
        logic [PTE_W-1:0] p;
        logic ok;
        idx = {fetch & ~wr, mdl_as, la[LA_W-1:OFS_W]};
        p   = mdl_pte[idx];
        ok  = (mdl_key == 0) || (mdl_key == p[11:8]) || (p[11:8] == 4'hF);
        if (wr && p[12]) ok = 1'b0;
        if (fetch && !wr && p[13]) ok = 1'b0;
        e.paddr = {p[7:0], la[OFS_W-1:0]};
        e.hit = ok;
        e.fault = !ok;
        e.tag = tag;
        exp_q.push_back(e);
        acc_valid = 1'b1; acc_fetch = fetch; acc_write = wr; acc_laddr = la;
        @(negedge clk);
        acc_valid = 1'b0; acc_fetch = 1'b0; acc_write = 1'b0;
    endtask

    task automatic io_write(logic sel, logic [IDX_W-1:0] a, logic [IO_W-1:0] d);
        io_cmd_valid = 1'b1; io_cmd_wr = 1'b1; io_cmd_sel = sel;
        io_cmd_addr = a; io_cmd_wdata = d;
        if (sel) begin mdl_key = d[3:0]; mdl_as = d[7:4]; end
        else mdl_pte[a] = d;
        @(negedge clk);
        io_cmd_valid = 1'b0; io_cmd_wr = 1'b0;
    endtask

    task automatic io_read(string tag, logic sel, logic [IDX_W-1:0] a);
        logic [IO_W-1:0] exp;
        exp = sel ? IO_W'({mdl_as, mdl_key}) : mdl_pte[a];
        io_cmd_valid = 1'b1; io_cmd_wr = 1'b0; io_cmd_sel = sel; io_cmd_addr = a;
        @(negedge clk);
        io_cmd_valid = 1'b0;
        check({tag, " rsp_valid"}, 32'(io_rsp_valid), 32'd1);
        check({tag, " rsp_data"}, 32'(io_rsp_data), 32'(exp));
    endtask

    // Monitor: compares every produced result with the scoreboard head (R11 for strays)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R11 stray result", 32'(out_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " paddr"}, 32'(out_paddr), 32'(e.paddr));
                    check({e.tag, " hit"},   32'(out_hit),   32'(e.hit));
                    check({e.tag, " fault"}, 32'(out_fault), 32'(e.fault));
                end
            end else if (rst_n) begin
                if (out_hit || out_fault) check("R11 idle flags", {30'd0, out_hit, out_fault}, 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) mdl_pte[i] = PTE_W'(i % 16);
        mdl_as = '0; mdl_key = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 rsp_valid", 32'(io_rsp_valid), 32'd0);
        io_read("R1 identity entry", 1'b0, 9'h1A5);
        io_read("R1 status zero", 1'b1, '0);
        access("R1 identity map", 1'b0, 1'b0, 16'h7123);
        access("R2 fetch identity", 1'b1, 1'b0, 16'hC00F);
        // R8 program page 3 of set 0, key 0 passes by R4
        io_write(1'b0, 9'h003, 14'h05AB);
        access("R8 remapped", 1'b0, 1'b0, 16'h3456);
        io_read("R9 entry readback", 1'b0, 9'h003);
        // R4 key equals lock; R5 key mismatch
        io_write(1'b1, '0, 14'h0005);
        access("R4 key match", 1'b0, 1'b0, 16'h3001);
        io_write(1'b1, '0, 14'h0006);
        access("R5 key mismatch", 1'b0, 1'b0, 16'h3002);
        access("R5 lock0 nonzero key", 1'b0, 1'b0, 16'h7FFF);
        io_write(1'b0, 9'h006, 14'h0F21);
        access("R4 lock F open", 1'b0, 1'b1, 16'h6ABC);
        io_write(1'b1, '0, 14'h0000);
        // R6 write protect
        io_write(1'b0, 9'h004, 14'h1044);
        access("R6 write blocked", 1'b0, 1'b1, 16'h4010);
        access("R6 read allowed", 1'b0, 1'b0, 16'h4010);
        // R7 execute protect on fetch entry, operand entry untouched
        io_write(1'b0, 9'h102, 14'h2090);
        access("R7 fetch blocked", 1'b1, 1'b0, 16'h2222);
        access("R7 operand read ok", 1'b0, 1'b0, 16'h2222);
        access("R3 fetch write uses operand", 1'b1, 1'b1, 16'h2223);
        // R10 address state picks mapping set; R3 index layout
        io_write(1'b1, '0, 14'h0030);
        io_write(1'b0, 9'h031, 14'h0077);
        io_write(1'b0, 9'h131, 14'h0066);
        access("R10 set 3 operand", 1'b0, 1'b0, 16'h1ABC);
        access("R3 set 3 fetch", 1'b1, 1'b0, 16'h1ABC);
        access("R10 set 3 identity", 1'b0, 1'b0, 16'h9000);
        io_read("R10 status readback", 1'b1, '0);
        // back-to-back accesses (R2)
        access("R2 burst a", 1'b0, 1'b0, 16'h1001);
        access("R2 burst b", 1'b0, 1'b1, 16'hF002);
        access("R2 burst c", 1'b1, 1'b0, 16'h1003);
        // idle cycles must show nothing (R11)
        repeat (4) @(negedge clk);
        check("R11 idle valid", 32'(out_valid), 32'd0);
        check("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule